// File: doc/BRIEF.md
# Timed Stream Command Queue

This block collects receive stream commands from a settings-register write port and hands each completed command to a downstream streaming controller. A command is written in three parts: a command word, a seconds timestamp and a ticks timestamp. The first two writes only load staging registers. The ticks write is the commit: it places the staged word, the staged seconds and the ticks value into a small command FIFO as one entry, in a single cycle. The FIFO drains through a valid/ready interface. The command word is decoded into an immediate-start flag, a chaining flag and a sample count.

A fourth register address acts as a strobe. Any write to it clears a latched overrun flag. The flag is set by a pulse on `ovr_event` from the streaming side. A commit that arrives while the FIFO is full is discarded and raises a sticky drop error. The FIFO occupancy is tracked by a three-state machine: `Q_EMPTY`, `Q_PART` and `Q_FULL`. Its transitions are:
- FILL (`Q_EMPTY` to `Q_PART` on a push).
- TOP_OFF (`Q_PART` to `Q_FULL` when a push without a pop brings the count to DEPTH).
- DRAIN_LAST (`Q_PART` to `Q_EMPTY` when a pop without a push removes the last entry).
- RELEASE (`Q_FULL` to `Q_PART` on a pop).

Top module: `tscq_top`

## Requirements
- R1: After reset, `cmd_valid`, `ovr_flag` and `drop_err` are 0, and both staging registers hold zero. A ticks write that follows reset with no other writes therefore enqueues a zero command word and zero seconds.
- R2: A write with `cfg_idx` = BASE+2 while the queue is not full enqueues one entry made of the staged command word, the staged seconds and the written data as ticks. `cmd_valid` is 1 from the cycle after the write.
- R3: Writes to BASE+0 (command word) and BASE+1 (seconds) only load staging and never enqueue. The staged values persist after a commit, so a later ticks write alone reuses them.
- R4: The head entry is presented with `cmd_now` = word bit 31, `cmd_chain` = word bit 30 and `cmd_count` = word bits 29:0, alongside `cmd_secs` and `cmd_ticks`.
- R5: Entries leave in write order. An entry is removed on a cycle with `cmd_valid` and `cmd_ready` both 1. While `cmd_valid` is 1 and `cmd_ready` is 0, the head entry and `cmd_valid` stay unchanged.
- R6: A ticks write while the queue holds DEPTH entries is discarded, even if a pop occurs in the same cycle. `drop_err` becomes 1 in the next cycle and stays 1 until reset.
- R7: A pulse on `ovr_event` sets `ovr_flag` in the next cycle.
- R8: Any write to BASE+3 clears `ovr_flag` in the next cycle, whatever the data. If `ovr_event` is 1 in the same cycle, the flag stays set.
- R9: Writes to indices outside BASE..BASE+3 change neither staging, the queue nor the flags.
- R10: A commit and a pop in the same cycle, on a queue that is neither empty nor full, both take effect. The occupancy is unchanged and the new entry goes behind the remaining ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_stb | input | 1 | Settings write strobe |
| cfg_idx | input | IDX_W | Settings register index |
| cfg_data | input | 32 | Settings write data |
| ovr_event | input | 1 | Overrun pulse from the streaming side |
| cmd_valid | output | 1 | Head command available |
| cmd_ready | input | 1 | Consumer accepts head command |
| cmd_now | output | 1 | Start immediately flag of head command |
| cmd_chain | output | 1 | Chain to next command flag |
| cmd_count | output | 30 | Number of samples requested |
| cmd_secs | output | 32 | Seconds timestamp |
| cmd_ticks | output | 32 | Ticks timestamp |
| ovr_flag | output | 1 | Latched overrun |
| drop_err | output | 1 | Sticky dropped-command error |

## Verification
The bench builds the block with DEPTH = 4, IDX_W = 8 and BASE = 0x20. The shallow queue makes the TOP_OFF and RELEASE transitions reachable within a few writes. This exposes the full-drop path, including a drop coincident with a pop, as well as a complete drain back to `Q_EMPTY`. A non-zero base lets the bench probe indices just below and just above the register window.

// File: rtl/tscq_pkg.sv
package tscq_pkg;
    localparam int unsigned TSCQ_WORD_W  = 32;
    localparam int unsigned TSCQ_COUNT_W = TSCQ_WORD_W - 2;

    typedef struct packed {
        logic                    now;
        logic                    chain;
        logic [TSCQ_COUNT_W-1:0] count;
        logic [TSCQ_WORD_W-1:0]  secs;
        logic [TSCQ_WORD_W-1:0]  ticks;
    } tscq_cmd_t;

    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_PART  = 2'd1,
        Q_FULL  = 2'd2
    } tscq_qstate_t;
endpackage

// File: rtl/tscq_regs.sv
module tscq_regs
    import tscq_pkg::*;
#(
    parameter int unsigned           IDX_W = 8,
    parameter logic [IDX_W-1:0]      BASE  = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_stb,
    input  logic [IDX_W-1:0]        cfg_idx,
    input  logic [TSCQ_WORD_W-1:0]  cfg_data,
    output logic                    push_req,
    output tscq_cmd_t               push_cmd,
    output logic                    ovr_clr
);
    localparam logic [IDX_W-1:0] IDX_WORD = BASE;
    localparam logic [IDX_W-1:0] IDX_SECS = IDX_W'(BASE + 1);
    localparam logic [IDX_W-1:0] IDX_TICK = IDX_W'(BASE + 2);
    localparam logic [IDX_W-1:0] IDX_CLR  = IDX_W'(BASE + 3);

    logic [TSCQ_WORD_W-1:0] stg_word;
    logic [TSCQ_WORD_W-1:0] stg_secs;
    logic hit_word, hit_secs, hit_tick, hit_clr;

    always_comb begin
        hit_word = cfg_stb && (cfg_idx == IDX_WORD);
        hit_secs = cfg_stb && (cfg_idx == IDX_SECS);
        hit_tick = cfg_stb && (cfg_idx == IDX_TICK);
        hit_clr  = cfg_stb && (cfg_idx == IDX_CLR);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_word <= '0;
            stg_secs <= '0;
        end else begin
            if (hit_word) stg_word <= cfg_data;
            if (hit_secs) stg_secs <= cfg_data;
        end
    end

    always_comb begin
        push_req       = hit_tick;
        ovr_clr        = hit_clr;
        push_cmd.now   = stg_word[TSCQ_WORD_W-1];
        push_cmd.chain = stg_word[TSCQ_WORD_W-2];
        push_cmd.count = stg_word[TSCQ_COUNT_W-1:0];
        push_cmd.secs  = stg_secs;
        push_cmd.ticks = cfg_data;
    end
endmodule

// File: rtl/tscq_fifo.sv
module tscq_fifo
    import tscq_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_req,
    input  tscq_cmd_t                    push_cmd,
    input  logic                         pop_ready,
    output tscq_cmd_t                    head,
    output logic                         head_valid,
    output logic                         full,
    output logic                         drop_pulse,
    output logic [$clog2(DEPTH+1)-1:0]   fill
);
    localparam int unsigned PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W    = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [PTR_W-1:0] PTR_END  = PTR_W'(DEPTH - 1);

    tscq_qstate_t q_state, q_state_nx;
    tscq_cmd_t    slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_ptr_inc, rd_ptr_inc;
    logic wr_ok, rd_ok;

    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
            assign wr_ptr_inc = wr_ptr + 1'b1;
            assign rd_ptr_inc = rd_ptr + 1'b1;
        end else begin : g_cmp_wrap
            assign wr_ptr_inc = (wr_ptr == PTR_END) ? '0 : wr_ptr + 1'b1;
            assign rd_ptr_inc = (rd_ptr == PTR_END) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    always_comb begin
        wr_ok = push_req && (q_state != Q_FULL);
        rd_ok = pop_ready && (q_state != Q_EMPTY);
    end

    // Next-state logic: FILL, TOP_OFF, DRAIN_LAST, RELEASE
    always_comb begin
        q_state_nx = q_state;
        unique case (q_state)
            Q_EMPTY: if (wr_ok) q_state_nx = Q_PART;
            Q_PART: begin
                if (wr_ok && !rd_ok && fill == CNT_LAST)
                    q_state_nx = Q_FULL;
                else if (rd_ok && !wr_ok && fill == CNT_ONE)
                    q_state_nx = Q_EMPTY;
            end
            Q_FULL:  if (rd_ok) q_state_nx = Q_PART;
            default: q_state_nx = Q_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_state <= Q_EMPTY;
        else        q_state <= q_state_nx;
    end

    always_comb begin
        head_valid = (q_state != Q_EMPTY);
        full       = (q_state == Q_FULL);
        drop_pulse = push_req && (q_state == Q_FULL);
        head       = slots[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (wr_ok) wr_ptr <= wr_ptr_inc;
            if (rd_ok) rd_ptr <= rd_ptr_inc;
            if (wr_ok && !rd_ok)      fill <= fill + 1'b1;
            else if (rd_ok && !wr_ok) fill <= fill - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok) slots[wr_ptr] <= push_cmd;
    end

    logic unused_top;
    assign unused_top = (CNT_TOP == '0);
endmodule

// File: rtl/tscq_flags.sv
module tscq_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic ovr_event,
    input  logic ovr_clr,
    input  logic drop_pulse,
    output logic ovr_flag,
    output logic drop_err
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_flag <= 1'b0;
            drop_err <= 1'b0;
        end else begin
            if (ovr_event)    ovr_flag <= 1'b1;
            else if (ovr_clr) ovr_flag <= 1'b0;
            if (drop_pulse)   drop_err <= 1'b1;
        end
    end
endmodule

// File: rtl/tscq_top.sv
module tscq_top
    import tscq_pkg::*;
#(
    parameter int unsigned      IDX_W = 8,
    parameter logic [IDX_W-1:0] BASE  = '0,
    parameter int unsigned      DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_stb,
    input  logic [IDX_W-1:0]         cfg_idx,
    input  logic [TSCQ_WORD_W-1:0]   cfg_data,
    input  logic                     ovr_event,
    output logic                     cmd_valid,
    input  logic                     cmd_ready,
    output logic                     cmd_now,
    output logic                     cmd_chain,
    output logic [TSCQ_COUNT_W-1:0]  cmd_count,
    output logic [TSCQ_WORD_W-1:0]   cmd_secs,
    output logic [TSCQ_WORD_W-1:0]   cmd_ticks,
    output logic                     ovr_flag,
    output logic                     drop_err
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic       push_req, ovr_clr, drop_pulse, q_full;
    tscq_cmd_t  push_cmd, head;
    logic [CNT_W-1:0] q_count;

    tscq_regs #(.IDX_W(IDX_W), .BASE(BASE)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_stb(cfg_stb), .cfg_idx(cfg_idx),
        .cfg_data(cfg_data), .push_req(push_req), .push_cmd(push_cmd),
        .ovr_clr(ovr_clr)
    );

    tscq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_req(push_req), .push_cmd(push_cmd),
        .pop_ready(cmd_ready), .head(head), .head_valid(cmd_valid),
        .full(q_full), .drop_pulse(drop_pulse), .fill(q_count)
    );

    tscq_flags u_flags (
        .clk(clk), .rst_n(rst_n), .ovr_event(ovr_event), .ovr_clr(ovr_clr),
        .drop_pulse(drop_pulse), .ovr_flag(ovr_flag), .drop_err(drop_err)
    );

    always_comb begin
        cmd_now   = head.now;
        cmd_chain = head.chain;
        cmd_count = head.count;
        cmd_secs  = head.secs;
        cmd_ticks = head.ticks;
    end
endmodule

// File: rtl/tscq_chk.sv
module tscq_chk #(
    parameter int unsigned      IDX_W = 8,
    parameter logic [IDX_W-1:0] BASE  = '0,
    parameter int unsigned      DEPTH = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        cfg_stb,
    input logic [IDX_W-1:0]            cfg_idx,
    input logic                        ovr_event,
    input logic                        cmd_valid,
    input logic                        cmd_ready,
    input logic [31:0]                 cmd_secs,
    input logic [31:0]                 cmd_ticks,
    input logic                        ovr_flag,
    input logic                        drop_err,
    input logic                        q_full,
    input logic [$clog2(DEPTH+1)-1:0]  q_count
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    logic tick_wr, clr_wr;
    assign tick_wr = cfg_stb && (cfg_idx == IDX_W'(BASE + 2));
    assign clr_wr  = cfg_stb && (cfg_idx == IDX_W'(BASE + 3));

    a_r2_commit_valid: assert property (@(posedge clk) disable iff (!rst_n)
        tick_wr && !q_full |=> cmd_valid);
    a_r6_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
        tick_wr && q_full |=> drop_err);
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        drop_err |=> drop_err);
    a_r5_head_held: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_ticks) && $stable(cmd_secs));
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CNT_W'(DEPTH));
    a_r7_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_event |=> ovr_flag);
    a_r8_ovr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr && !ovr_event |=> !ovr_flag);
    a_r10_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
        tick_wr && !q_full && cmd_valid && cmd_ready |=> q_count == $past(q_count));
endmodule

bind tscq_top tscq_chk #(.IDX_W(IDX_W), .BASE(BASE), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_stb(cfg_stb), .cfg_idx(cfg_idx),
    .ovr_event(ovr_event), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_secs(cmd_secs), .cmd_ticks(cmd_ticks), .ovr_flag(ovr_flag),
    .drop_err(drop_err), .q_full(q_full), .q_count(q_count)
);

// File: tb/tscq_top_test.sv
module tscq_top_test;
    localparam int unsigned      IDX_W = 8;
    localparam logic [7:0]       BASE  = 8'h20;
    localparam int unsigned      DEPTH = 4;
    localparam logic [7:0] I_WORD = BASE, I_SECS = BASE + 8'd1;
    localparam logic [7:0] I_TICK = BASE + 8'd2, I_CLR = BASE + 8'd3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_stb = 1'b0;
    logic [7:0] cfg_idx = '0;
    logic [31:0] cfg_data = '0;
    logic ovr_event = 1'b0;
    logic cmd_ready = 1'b0;
    logic cmd_valid, cmd_now, cmd_chain, ovr_flag, drop_err;
    logic [29:0] cmd_count;
    logic [31:0] cmd_secs, cmd_ticks;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] m_word = '0;
    logic [31:0] m_secs = '0;
    logic [95:0] exp_q[$];

    always #2.5 clk = ~clk;

    tscq_top #(.IDX_W(IDX_W), .BASE(BASE), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_stb(cfg_stb), .cfg_idx(cfg_idx),
        .cfg_data(cfg_data), .ovr_event(ovr_event), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_now(cmd_now), .cmd_chain(cmd_chain),
        .cmd_count(cmd_count), .cmd_secs(cmd_secs), .cmd_ticks(cmd_ticks),
        .ovr_flag(ovr_flag), .drop_err(drop_err)
    );

    task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [95:0] head_bits();
        return {cmd_now, cmd_chain, cmd_count, cmd_secs, cmd_ticks};
    endfunction

    // one settings write, model updated afterwards
    task automatic wr(input logic [7:0] idx, input logic [31:0] d);
        @(negedge clk);
        cfg_stb = 1'b1; cfg_idx = idx; cfg_data = d;
        @(posedge clk); #1;
        cfg_stb = 1'b0;
        if (idx == I_WORD) m_word = d;
        if (idx == I_SECS) m_secs = d;
        if (idx == I_TICK && exp_q.size() < DEPTH) exp_q.push_back({m_word, m_secs, d});
    endtask

    task automatic pop_chk(input string req);
        chk({req, " valid"}, 96'(cmd_valid), 96'd1);
        if (exp_q.size() > 0) chk({req, " head"}, head_bits(), exp_q[0]);
        @(negedge clk); cmd_ready = 1'b1;
        @(posedge clk); #1; cmd_ready = 1'b0;
        if (exp_q.size() > 0) void'(exp_q.pop_front());
    endtask

    task automatic push_pop(input logic [31:0] d);
        @(negedge clk);
        cfg_stb = 1'b1; cfg_idx = I_TICK; cfg_data = d; cmd_ready = 1'b1;
        @(posedge clk); #1;
        cfg_stb = 1'b0; cmd_ready = 1'b0;
        if (exp_q.size() < DEPTH) begin
            void'(exp_q.pop_front());
            exp_q.push_back({m_word, m_secs, d});
        end else void'(exp_q.pop_front());
    endtask

    task automatic drain(input string req);
        while (exp_q.size() > 0) pop_chk(req);
        chk({req, " empty"}, 96'(cmd_valid), 96'd0);
    endtask

    task automatic t_reset;
        chk("R1 valid", 96'(cmd_valid), 96'd0);
        chk("R1 ovr", 96'(ovr_flag), 96'd0);
        chk("R1 err", 96'(drop_err), 96'd0);
        wr(I_TICK, 32'h0000_1111);
        chk("R1 staging zero", head_bits(), {64'd0, 32'h0000_1111});
        drain("R1");
    endtask

    task automatic t_basic;
        wr(I_WORD, 32'hC000_0040);
        chk("R3 word no push", 96'(cmd_valid), 96'd0);
        wr(I_SECS, 32'h0000_0123);
        chk("R3 secs no push", 96'(cmd_valid), 96'd0);
        wr(I_TICK, 32'h0ABC_DEF0);
        chk("R2 valid after commit", 96'(cmd_valid), 96'd1);
        chk("R4 now", 96'(cmd_now), 96'd1);
        chk("R4 chain", 96'(cmd_chain), 96'd1);
        chk("R4 count", 96'(cmd_count), 96'h40);
        chk("R2 entry", head_bits(), {32'hC000_0040, 32'h0000_0123, 32'h0ABC_DEF0});
        drain("R2");
        wr(I_WORD, 32'h4000_0007);
        wr(I_TICK, 32'h0000_0005);
        chk("R4 now clear", 96'(cmd_now), 96'd0);
        chk("R4 chain set", 96'(cmd_chain), 96'd1);
        wr(I_TICK, 32'h0000_0006);
        drain("R3 staging reused");
    endtask

    task automatic t_order;
        wr(I_WORD, 32'h8000_0001); wr(I_SECS, 32'd10); wr(I_TICK, 32'd100);
        wr(I_WORD, 32'h0000_0002); wr(I_SECS, 32'd20); wr(I_TICK, 32'd200);
        repeat (3) @(posedge clk);
        #1;
        chk("R5 held head", head_bits(), exp_q[0]);
        chk("R5 held valid", 96'(cmd_valid), 96'd1);
        drain("R5 order");
    endtask

    task automatic t_ignore;
        wr(I_WORD, 32'h1234_5678);
        wr(I_SECS, 32'h0000_00AA);
        wr(BASE - 8'd1, 32'hFFFF_FFFF);
        wr(BASE + 8'd4, 32'hEEEE_EEEE);
        chk("R9 no push", 96'(cmd_valid), 96'd0);
        chk("R9 flags", {94'd0, ovr_flag, drop_err}, 96'd0);
        wr(I_TICK, 32'd7);
        chk("R9 staging kept", head_bits(), {32'h1234_5678, 32'h0000_00AA, 32'd7});
        drain("R9");
    endtask

    task automatic t_simul;
        wr(I_TICK, 32'd1);
        wr(I_TICK, 32'd2);
        push_pop(32'd3);
        chk("R10 head after push+pop", head_bits(), exp_q[0]);
        drain("R10");
    endtask

    task automatic t_full;
        for (int i = 0; i < DEPTH; i++) wr(I_TICK, 32'd50 + 32'(i));
        chk("R6 err before drop", 96'(drop_err), 96'd0);
        wr(I_TICK, 32'd99);
        chk("R6 err set", 96'(drop_err), 96'd1);
        push_pop(32'd98);
        chk("R6 err sticky", 96'(drop_err), 96'd1);
        drain("R6 dropped absent");
        chk("R6 err after drain", 96'(drop_err), 96'd1);
    endtask

    task automatic t_overrun;
        @(negedge clk); ovr_event = 1'b1;
        @(posedge clk); #1; ovr_event = 1'b0;
        chk("R7 set", 96'(ovr_flag), 96'd1);
        wr(I_CLR, 32'd0);
        chk("R8 cleared", 96'(ovr_flag), 96'd0);
        @(negedge clk); ovr_event = 1'b1; cfg_stb = 1'b1; cfg_idx = I_CLR; cfg_data = 32'h5;
        @(posedge clk); #1; ovr_event = 1'b0; cfg_stb = 1'b0;
        chk("R8 set wins", 96'(ovr_flag), 96'd1);
        chk("R8 no push", 96'(cmd_valid), 96'd0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_basic();
        t_order();
        t_ignore();
        t_simul();
        t_overrun();
        t_full();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule